// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block holds a set of display configuration words in two copies. Software writes through a small register bus into a pending copy. The display datapath sees only an active copy. The active copy changes only when a vertical blanking interval begins, so a frame is never drawn from a half-written set of settings.

A control word chooses how the transfer is triggered. With automatic loading enabled, every start of blanking copies the whole pending copy into the active copy. With automatic loading disabled, a copy happens only after software has set a load-request bit. That bit reads back as one while the request is waiting, and it clears by itself at the blank that performs the copy, so software can poll it to learn when the commit has finished. A normal commit is a single write of 0x3 to the control word, which sets both bits at once.

Top module: `dbuf_cfg_bank`

## Requirements
- R1: After reset, every pending and active word is zero and the control word reads 0: automatic loading is enabled and no request is waiting.
- R2: Registers are 32 bits wide at a byte stride of 4. Byte address 0x0 is the control word and configuration word k (k = 0 to NUM_REGS-1) is at byte address 4*(k+1). A write updates the pending copy. A read returns the pending copy on bus_rdata one cycle after bus_rd is sampled, and bus_rdata holds its value while no read is issued. A write alone never changes active_cfg.
- R3: While control bit 1 is 0, the clock edge that first samples vblank high after it was low copies every pending word into active_cfg (word k at bits 32*k+31 down to 32*k).
- R4: While control bit 1 is 1 and no request is waiting, the start of blanking leaves active_cfg unchanged. Control bit 1 reads back as written.
- R5: Writing 1 to control bit 0 starts a request. Bit 0 reads 1 until the next blanking start, which copies pending to active, and it reads 0 after that.
- R6: If a configuration write lands in the same cycle as the blanking start that performs a copy, active_cfg receives the value held before the write and the pending copy receives the new value.
- R7: A request made while vblank is already high does not copy during that interval. It copies at the next low-to-high change of vblank. At most one copy happens for each blanking start.
- R8: Writing 0 to control bit 0 does not cancel a waiting request.
- R9: An access whose address is misaligned (address bits 1:0 not zero) or lies above the last configuration word is ignored for writes and returns 0 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vblank | input | 1 | High during vertical blanking; its rising edge is the transfer point |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_rd |
| active_cfg | output | NUM_REGS*32 (128) | Active copy of all configuration words, as seen by the datapath |

## Verification
A write lands in the pending copy at the edge that samples it. A read issued at a later edge has its data on bus_rdata right after that edge. active_cfg and the request bit change at the edge that first sees vblank high. The bench drives every input on falling edges. It queues each read's expected word when it issues the read, and compares it one full cycle later on a falling edge. It checks active_cfg on falling edges after the transfer edge, and again while vblank is still high to show that nothing changed before the edge that should cause the copy.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    localparam int BUS_DATA_W      = 32;
    localparam int CTRL_LOAD_BIT   = 0;
    localparam int CTRL_NOAUTO_BIT = 1;

    // state of the transfer controller
    typedef struct packed {
        logic vb_seen;   // vblank as sampled at the previous edge
        logic load;      // commit request waiting for a blank
        logic noauto;    // automatic per-frame loading disabled
    } ctrl_state_t;

endpackage

// File: rtl/dbuf_ctrl.sv
module dbuf_ctrl
    import dbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vblank,
    input  logic ctrl_we,
    input  logic set_load,
    input  logic noauto_in,
    output logic xfer,
    output logic load_req,
    output logic noauto
);

    ctrl_state_t s_q, s_d;
    logic        blank_start;

    always_comb begin
        s_d         = s_q;
        blank_start = vblank && !s_q.vb_seen;
        xfer        = blank_start && (s_q.load || !s_q.noauto);
        s_d.vb_seen = vblank;
        if (xfer) begin
            s_d.load = 1'b0;
        end
        if (ctrl_we) begin
            if (set_load) begin
                s_d.load = 1'b1;
            end
            s_d.noauto = noauto_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign load_req = s_q.load;
    assign noauto   = s_q.noauto;

    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !xfer) |=> load_req); // R8

    AST_REQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !(ctrl_we && set_load)) |=> !load_req); // R5

    AST_ONE_XFER_PER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !xfer); // R7

endmodule

// File: rtl/dbuf_regfile.sv
module dbuf_regfile #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [IDX_W-1:0]           widx,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       xfer,
    output logic [NUM_REGS*DATA_W-1:0] pending_flat,
    output logic [NUM_REGS*DATA_W-1:0] active_flat
);

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] act;
    } slot_t;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g + 1);

        slot_t s_q, s_d;

        always_comb begin
            s_d = s_q;
            // the copy takes the value held before any write in this cycle
            if (xfer) begin
                s_d.act = s_q.pend;
            end
            if (cfg_we && (widx == MY_IDX)) begin
                s_d.pend = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s_q <= '0;
            end else begin
                s_q <= s_d;
            end
        end

        assign pending_flat[g*DATA_W +: DATA_W] = s_q.pend;
        assign active_flat[g*DATA_W +: DATA_W]  = s_q.act;
    end

endmodule

// File: rtl/dbuf_rdmux.sv
module dbuf_rdmux #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd,
    input  logic                       aligned,
    input  logic [IDX_W-1:0]           ridx,
    input  logic                       load_req,
    input  logic                       noauto,
    input  logic [NUM_REGS*DATA_W-1:0] pending_flat,
    output logic [DATA_W-1:0]          rdata
);

    import dbuf_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t         s_q, s_d;
    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        if (aligned) begin
            if (ridx == '0) begin
                sel[CTRL_LOAD_BIT]   = load_req;
                sel[CTRL_NOAUTO_BIT] = noauto;
            end
            for (int i = 0; i < NUM_REGS; i++) begin
                if (ridx == IDX_W'(i + 1)) begin
                    sel = pending_flat[i*DATA_W +: DATA_W];
                end
            end
        end
        s_d = s_q;
        if (rd) begin
            s_d.rdata = sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rdata;

    AST_BAD_ADDR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !aligned) |=> (rdata == '0)); // R9

endmodule

// File: rtl/dbuf_cfg_bank.sv
module dbuf_cfg_bank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2((NUM_REGS + 1) * 4)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vblank,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [NUM_REGS*DATA_W-1:0] active_cfg
);

    import dbuf_pkg::*;

    localparam int               IDX_W    = ADDR_W - 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS);

    logic                       aligned;
    logic [IDX_W-1:0]           idx;
    logic                       ctrl_we;
    logic                       cfg_we;
    logic                       xfer;
    logic                       load_req;
    logic                       noauto;
    logic [NUM_REGS*DATA_W-1:0] pending_flat;

    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        idx     = bus_addr[ADDR_W-1:2];
        ctrl_we = bus_wr && aligned && (idx == '0);
        cfg_we  = bus_wr && aligned && (idx != '0) && (idx <= LAST_IDX);
    end

    dbuf_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .vblank    (vblank),
        .ctrl_we   (ctrl_we),
        .set_load  (bus_wdata[CTRL_LOAD_BIT]),
        .noauto_in (bus_wdata[CTRL_NOAUTO_BIT]),
        .xfer      (xfer),
        .load_req  (load_req),
        .noauto    (noauto)
    );

    dbuf_regfile #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .widx         (idx),
        .wdata        (bus_wdata),
        .xfer         (xfer),
        .pending_flat (pending_flat),
        .active_flat  (active_cfg)
    );

    dbuf_rdmux #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_rdmux (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd           (bus_rd),
        .aligned      (aligned),
        .ridx         (idx),
        .load_req     (load_req),
        .noauto       (noauto),
        .pending_flat (pending_flat),
        .rdata        (bus_rdata)
    );

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(active_cfg)); // R4

    AST_ACTIVE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (active_cfg == $past(pending_flat))); // R3

    AST_XFER_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> vblank); // R7

endmodule

// File: tb/dbuf_cfg_bank_bench.sv
module dbuf_cfg_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_REGS   = 4;
    localparam int DW         = 32;
    localparam int AW         = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               vblank = 1'b0;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [AW-1:0]      bus_addr = '0;
    logic [DW-1:0]      bus_wdata = '0;
    wire  [DW-1:0]      bus_rdata;
    wire  [NUM_REGS*DW-1:0] active_cfg;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbuf_cfg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DW), .ADDR_W(AW)) u_dbuf_cfg_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .vblank     (vblank),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .active_cfg (active_cfg)
    );

    // monitor: a read sampled at a rising edge is compared at the next falling edge
    logic rd_seen = 1'b0;
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        exp_t e;
        if (rd_seen) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_err++;
                $display("FAIL read with no expected entry: actual %h expected none", bus_rdata);
            end else begin
                e = sb.pop_front();
                if (bus_rdata !== e.exp) begin
                    n_err++;
                    $display("FAIL %s: actual %h expected %h", e.tag, bus_rdata, e.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        sb.push_back('{exp, tag});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_active(input int k, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (active_cfg[k*DW +: DW] !== exp) begin
            n_err++;
            $display("FAIL %s: active word %0d actual %h expected %h", tag, k, active_cfg[k*DW +: DW], exp);
        end
    endtask

    task automatic blank_pulse();
        @(negedge clk);
        vblank = 1'b1;
        repeat (3) @(negedge clk);
        vblank = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < NUM_REGS; k++) chk_active(k, '0, "R1 active after reset");
        bus_read(5'h00, 32'h0, "R1 control after reset");
        bus_read(5'h08, 32'h0, "R1 pending after reset");

        // R2: writes land in pending, readback, active untouched
        bus_write(5'h04, 32'hA1A1_0001);
        bus_write(5'h10, 32'hD4D4_0004);
        bus_read(5'h04, 32'hA1A1_0001, "R2 readback word0");
        bus_read(5'h10, 32'hD4D4_0004, "R2 readback word3");
        chk_active(0, '0, "R2 active word0 before blank");
        chk_active(3, '0, "R2 active word3 before blank");
        repeat (2) @(negedge clk);
        n_chk++;
        if (bus_rdata !== 32'hD4D4_0004) begin
            n_err++;
            $display("FAIL R2 rdata hold: actual %h expected %h", bus_rdata, 32'hD4D4_0004);
        end

        // R3: autoload copies at blank start
        blank_pulse();
        chk_active(0, 32'hA1A1_0001, "R3 autoload word0");
        chk_active(3, 32'hD4D4_0004, "R3 autoload word3");

        // R4: autoload disabled, no request
        bus_write(5'h00, 32'h2);
        bus_read(5'h00, 32'h2, "R4 control readback");
        bus_write(5'h08, 32'hB2B2_0002);
        blank_pulse();
        chk_active(1, '0, "R4 no copy without request");
        bus_read(5'h08, 32'hB2B2_0002, "R4 pending kept");

        // R5 and R8: commit request, polled, not cancelled by a zero write
        bus_write(5'h00, 32'h3);
        bus_read(5'h00, 32'h3, "R5 request pending");
        chk_active(1, '0, "R5 no copy before blank");
        bus_write(5'h00, 32'h2);
        bus_read(5'h00, 32'h3, "R8 zero write keeps request");
        blank_pulse();
        chk_active(1, 32'hB2B2_0002, "R5 commit copied");
        bus_read(5'h00, 32'h2, "R5 request cleared");

        // R7: request raised inside blanking waits for next blank start
        @(negedge clk);
        vblank = 1'b1;
        bus_write(5'h0C, 32'hC3C3_0003);
        bus_write(5'h00, 32'h3);
        bus_read(5'h00, 32'h3, "R7 request waits during blank");
        chk_active(2, '0, "R7 no copy inside current blank");
        @(negedge clk);
        vblank = 1'b0;
        repeat (2) @(negedge clk);
        chk_active(2, '0, "R7 no copy at blank end");
        blank_pulse();
        chk_active(2, 32'hC3C3_0003, "R7 copy at next blank");
        bus_read(5'h00, 32'h2, "R7 request cleared");

        // R6: write coinciding with the transfer edge
        bus_write(5'h00, 32'h0);
        bus_write(5'h04, 32'h1111_1111);
        chk_active(0, 32'hA1A1_0001, "R6 setup no copy");
        @(negedge clk);
        vblank = 1'b1;
        bus_wr = 1'b1; bus_addr = 5'h04; bus_wdata = 32'h2222_2222;
        @(negedge clk);
        bus_wr = 1'b0;
        chk_active(0, 32'h1111_1111, "R6 active takes old pending");
        bus_read(5'h04, 32'h2222_2222, "R6 pending takes new write");
        @(negedge clk);
        vblank = 1'b0;
        @(negedge clk);

        // R9: misaligned and out-of-range accesses
        bus_write(5'h14, 32'hDEAD_BEEF);
        bus_write(5'h05, 32'h0BAD_0BAD);
        bus_read(5'h14, 32'h0, "R9 out of range reads zero");
        bus_read(5'h05, 32'h0, "R9 misaligned reads zero");
        bus_read(5'h04, 32'h2222_2222, "R9 word0 untouched");
        bus_read(5'h08, 32'hB2B2_0002, "R9 word1 untouched");
        bus_read(5'h0C, 32'hC3C3_0003, "R9 word2 untouched");
        bus_read(5'h10, 32'hD4D4_0004, "R9 word3 untouched");
        blank_pulse();
        chk_active(0, 32'h2222_2222, "R3 autoload after re-enable");
        chk_active(1, 32'hB2B2_0002, "R9 active word1 untouched");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_chk++;
            n_err++;
            $display("FAIL R2 reads outstanding: actual %0d expected 0", sb.size());
        end
        finish_run();
    end

endmodule